// File: doc/BRIEF.md
# Palette DAC Write Port

This block holds a 256-entry colour lookup table, with one byte each of red, green and blue per entry, and the byte-wide register port that loads it. Software loads the table through two registers. The index register at offset 0x0 picks the entry to load and restarts the component sequence. The colour-map data register at offset 0x4 takes one component per byte: red, then green, then blue of the current entry. After the blue byte the block moves on to the next entry. A single bus write may carry one to four bytes, so one word write can fill a whole entry and spill into the next one.

A second port is combinational and always available. The scanout logic presents an 8-bit pixel value on it and gets back the 24-bit colour of that entry in the same cycle. Each data write raises a redraw request flag, which tells scanout that the whole frame must be repainted with the new colours. Scanout clears the flag with a one-cycle pulse when it finishes a frame.

Top module: `pal_dac_wport`

## Requirements
- R1: A write to offset 0x0 loads wr_data_i[7:0] as the current entry and sets the phase to red. It also abandons a partly written entry, so the next data byte goes to the red component of the newly selected entry.
- R2: Successive data bytes go to the red, green and blue components of the current entry, in that order. After the blue byte the phase returns to red.
- R3: Each blue byte moves the current entry to the next one, and entry 255 wraps to entry 0.
- R4: A write to offset 0x4 carries wr_len_i+1 bytes (wr_len_i from 0 to 3). The bytes are taken from the low end of wr_data_i, most significant byte first: byte k is wr_data_i[8*(wr_len_i-k)+7 : 8*(wr_len_i-k)]. Each byte is one component, in sequence, and the data bits above the carried bytes are ignored.
- R5: A write to any offset other than 0x0 and 0x4 changes neither the table, the current entry, the phase, nor the redraw flag.
- R6: rd_data_o reads as zero at all times, for both registers.
- R7: rgb_o equals {red, green, blue} of entry pix_i in the same cycle, with red in bits 23:16 and blue in bits 7:0.
- R8: A data write sets redraw_o from the next cycle on. A write to the index register leaves redraw_o unchanged.
- R9: A pulse on redraw_clr_i clears redraw_o from the next cycle on. If the pulse comes in the same cycle as a data write, the flag stays set.
- R10: Reset clears every component of every entry to zero, sets the current entry to 0 and the phase to red, and sets redraw_o to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte offset of the register written |
| wr_len_i | input | 2 | Number of bytes in the write, minus one |
| wr_data_i | input | 32 | Write data, right-justified |
| rd_data_o | output | 32 | Register read data (always zero) |
| pix_i | input | 8 | Scanout lookup address |
| rgb_o | output | 24 | Colour of entry pix_i |
| redraw_clr_i | input | 1 | End-of-frame clear of the redraw request |
| redraw_o | output | 1 | Full-redraw request |

## Verification
Single-byte writes check the plain red/green/blue order and the advance to the next entry. Word writes of two and four bytes, starting in the red, green and blue phases, separate a correct byte order and lane-to-entry spill from byte-swapped or misaligned unpacking. An index write in the middle of an entry, a write to an unused offset and a write sequence across entry 255 isolate the phase reset, the address decode and the wrap. A clear pulse given alone and then together with a data write separates the two priority orders of the redraw flag.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned NCOMP = 3;
  localparam logic [1:0] PH_R = 2'd0;
  localparam logic [1:0] PH_G = 2'd1;
  localparam logic [1:0] PH_B = 2'd2;
endpackage

// File: rtl/pal_seq.sv
module pal_seq #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned LANES = 4,
  localparam int unsigned LEN_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_we_i,
  input  logic [IDX_W-1:0] idx_val_i,
  input  logic             dat_we_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             lane_en_o  [LANES],
  output logic [IDX_W-1:0] lane_idx_o [LANES],
  output logic [1:0]       lane_ph_o  [LANES]
);
  import pal_pkg::*;

  logic [IDX_W-1:0] idx_q;
  logic [1:0]       ph_q;
  logic [IDX_W-1:0] idx_n;
  logic [1:0]       ph_n;
  logic [3:0]       tot;

  // lane k lands at phase offset ph+k; crossing blue moves to next entry
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic [3:0] step;
      step = 4'(ph_q) + 4'(k);
      lane_en_o[k]  = dat_we_i && (k <= int'(len_i));
      lane_ph_o[k]  = (step >= 4'd3) ? 2'(step - 4'd3) : 2'(step);
      lane_idx_o[k] = idx_q + IDX_W'(step >= 4'd3);
    end
  end

  always_comb begin
    tot = 4'(ph_q) + 4'(len_i) + 4'd1;
    if (tot >= 4'd6) begin
      ph_n  = 2'(tot - 4'd6);
      idx_n = idx_q + IDX_W'(2);
    end else if (tot >= 4'd3) begin
      ph_n  = 2'(tot - 4'd3);
      idx_n = idx_q + IDX_W'(1);
    end else begin
      ph_n  = 2'(tot);
      idx_n = idx_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ph_q  <= PH_R;
    end else if (idx_we_i) begin
      idx_q <= idx_val_i;
      ph_q  <= PH_R;
    end else if (dat_we_i) begin
      idx_q <= idx_n;
      ph_q  <= ph_n;
    end
  end

  // R1
  idx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_we_i |=> (ph_q == PH_R) && (idx_q == $past(idx_val_i)));
  // R2
  phase_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q != 2'd3);
  // R3
  idx_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_we_i && !idx_we_i && len_i == '0 && ph_q == PH_B)
      |=> (ph_q == PH_R) && (idx_q == IDX_W'($past(idx_q) + 1'b1)));
  // R5
  seq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_we_i && !dat_we_i) |=> $stable(idx_q) && $stable(ph_q));
endmodule

// File: rtl/pal_table.sv
module pal_table #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lane_en_i   [LANES],
  input  logic [IDX_W-1:0]  lane_idx_i  [LANES],
  input  logic [1:0]        lane_ph_i   [LANES],
  input  logic [COMP_W-1:0] lane_byte_i [LANES],
  input  logic [IDX_W-1:0]  pix_i,
  output logic [3*COMP_W-1:0] rgb_o
);
  import pal_pkg::*;

  logic [COMP_W-1:0] mem [NCOMP][DEPTH];

  // lanes of one write always hit distinct (component, entry) cells
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCOMP; c++)
        for (int e = 0; e < DEPTH; e++)
          mem[c][e] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (lane_en_i[l]) mem[lane_ph_i[l]][lane_idx_i[l]] <= lane_byte_i[l];
    end
  end

  assign rgb_o = {mem[PH_R][pix_i], mem[PH_G][pix_i], mem[PH_B][pix_i]};
endmodule

// File: rtl/pal_redraw.sv
module pal_redraw (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b1;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R8
  redraw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  // R9
  redraw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/pal_dac_wport.sv
module pal_dac_wport #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned IDX_W  = 8,
  parameter logic [ADDR_W-1:0] IDX_OFF = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] DAT_OFF = ADDR_W'(4),
  localparam int unsigned LANES = BUS_W / COMP_W,
  localparam int unsigned LEN_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [LEN_W-1:0]    wr_len_i,
  input  logic [BUS_W-1:0]    wr_data_i,
  output logic [BUS_W-1:0]    rd_data_o,
  input  logic [IDX_W-1:0]    pix_i,
  output logic [3*COMP_W-1:0] rgb_o,
  input  logic                redraw_clr_i,
  output logic                redraw_o
);
  logic             idx_we, dat_we;
  logic             lane_en   [LANES];
  logic [IDX_W-1:0] lane_idx  [LANES];
  logic [1:0]       lane_ph   [LANES];
  logic [COMP_W-1:0] lane_byte [LANES];

  assign idx_we    = wr_en_i && (addr_i == IDX_OFF);
  assign dat_we    = wr_en_i && (addr_i == DAT_OFF);
  assign rd_data_o = '0;

  // right-justified payload, first byte is the most significant carried one
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic [LEN_W-1:0] pos;
      pos = wr_len_i - LEN_W'(k);
      lane_byte[k] = COMP_W'(wr_data_i >> (COMP_W * int'(pos)));
    end
  end

  pal_seq #(.IDX_W(IDX_W), .LANES(LANES)) i_seq (
    .clk_i, .rst_ni,
    .idx_we_i   (idx_we),
    .idx_val_i  (wr_data_i[IDX_W-1:0]),
    .dat_we_i   (dat_we),
    .len_i      (wr_len_i),
    .lane_en_o  (lane_en),
    .lane_idx_o (lane_idx),
    .lane_ph_o  (lane_ph)
  );

  pal_table #(.IDX_W(IDX_W), .COMP_W(COMP_W), .LANES(LANES)) i_table (
    .clk_i, .rst_ni,
    .lane_en_i   (lane_en),
    .lane_idx_i  (lane_idx),
    .lane_ph_i   (lane_ph),
    .lane_byte_i (lane_byte),
    .pix_i,
    .rgb_o
  );

  pal_redraw i_redraw (
    .clk_i, .rst_ni,
    .set_i  (dat_we),
    .clr_i  (redraw_clr_i),
    .flag_o (redraw_o)
  );

  // R4
  lane_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we |-> lane_en[0]);
endmodule

// File: tb/test_pal_dac_wport.sv
module test_pal_dac_wport;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [1:0]  wr_len_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [7:0]  pix_i = '0;
  logic [23:0] rgb_o;
  logic        redraw_clr_i = 1'b0;
  logic        redraw_o;

  int vecs = 0, errs = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_dac_wport i_pal_dac_wport (
    .clk_i(clk), .rst_ni, .wr_en_i, .addr_i, .wr_len_i, .wr_data_i,
    .rd_data_o, .pix_i, .rgb_o, .redraw_clr_i, .redraw_o
  );

  // behavioural reference
  int mr[256], mg[256], mb[256];
  int mph, midx;
  bit mred;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < 256; e++) begin mr[e] = 0; mg[e] = 0; mb[e] = 0; end
      mph = 0; midx = 0; mred = 1;
    end else begin
      if (wr_en_i && addr_i == 5'd0) begin
        midx = wr_data_i[7:0]; mph = 0;
      end else if (wr_en_i && addr_i == 5'd4) begin
        int n;
        n = wr_len_i + 1;
        for (int k = 0; k < n; k++) begin
          int b;
          b = (wr_data_i >> (8 * (n - 1 - k))) & 255;
          if (mph == 0) mr[midx] = b;
          else if (mph == 1) mg[midx] = b;
          else mb[midx] = b;
          mph++;
          if (mph == 3) begin mph = 0; midx = (midx + 1) % 256; end
        end
      end
      if (wr_en_i && addr_i == 5'd4) mred = 1;
      else if (redraw_clr_i) mred = 0;
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    #2;
    if (rst_ni && !done) begin
      int exp;
      exp = (mr[pix_i] << 16) | (mg[pix_i] << 8) | mb[pix_i];
      vecs++;
      if (rgb_o !== 24'(exp)) begin
        errs++; $display("FAIL R7 model rgb pix=%0d got %h exp %h", pix_i, rgb_o, exp);
      end
      vecs++;
      if (redraw_o !== mred) begin
        errs++; $display("FAIL R8 model redraw got %b exp %b", redraw_o, mred);
      end
      vecs++;
      if (rd_data_o !== 32'd0) begin
        errs++; $display("FAIL R6 read data got %h exp 0", rd_data_o);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [1:0] l, input logic [31:0] d,
                    input bit clr = 0);
    wr_en_i = 1; addr_i = a; wr_len_i = l; wr_data_i = d; redraw_clr_i = clr;
    @(negedge clk);
    wr_en_i = 0; redraw_clr_i = 0; wr_data_i = '0;
  endtask

  task automatic pulse_clr();
    redraw_clr_i = 1;
    @(negedge clk);
    redraw_clr_i = 0;
  endtask

  task automatic chk_rgb(input string tag, input logic [7:0] p, input logic [23:0] exp);
    pix_i = p;
    #1;
    vecs++;
    if (rgb_o !== exp) begin
      errs++; $display("FAIL %s entry %0d got %h exp %h", tag, p, rgb_o, exp);
    end
  endtask

  task automatic chk_flag(input string tag, input logic exp);
    #1;
    vecs++;
    if (redraw_o !== exp) begin
      errs++; $display("FAIL %s redraw got %b exp %b", tag, redraw_o, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R10 reset state
    chk_rgb("R10", 8'd0, 24'h0);
    chk_rgb("R10", 8'd255, 24'h0);
    chk_flag("R10", 1'b1);
    vecs++;
    if (rd_data_o !== 32'd0) begin errs++; $display("FAIL R6 got %h exp 0", rd_data_o); end
    // R9 clear alone
    pulse_clr();
    chk_flag("R9", 1'b0);
    // R8 index write does not request redraw
    wr(5'd0, 2'd0, 32'd10);
    chk_flag("R8", 1'b0);
    // R2 single-byte sequence
    wr(5'd4, 2'd0, 32'h11);
    wr(5'd4, 2'd0, 32'h22);
    chk_rgb("R2", 8'd10, 24'h112200);
    chk_flag("R8", 1'b1);
    wr(5'd4, 2'd0, 32'h33);
    chk_rgb("R2", 8'd10, 24'h112233);
    // R3 advance after blue
    wr(5'd4, 2'd0, 32'h44);
    chk_rgb("R3", 8'd11, 24'h440000);
    // R1 index rewrite abandons partial entry
    wr(5'd0, 2'd0, 32'd20);
    wr(5'd4, 2'd0, 32'h55);
    chk_rgb("R1", 8'd20, 24'h550000);
    chk_rgb("R1", 8'd11, 24'h440000);
    // R4 four-byte words from red and green phases
    wr(5'd0, 2'd0, 32'd30);
    wr(5'd4, 2'd3, 32'hAABBCCDD);
    chk_rgb("R4", 8'd30, 24'hAABBCC);
    chk_rgb("R4", 8'd31, 24'hDD0000);
    wr(5'd4, 2'd3, 32'h01020304);
    chk_rgb("R4", 8'd31, 24'hDD0102);
    chk_rgb("R4", 8'd32, 24'h030400);
    // R4 two-byte write from blue phase, upper bits ignored
    wr(5'd4, 2'd1, 32'hFFFFEEFF);
    chk_rgb("R4", 8'd32, 24'h0304EE);
    chk_rgb("R4", 8'd33, 24'hFF0000);
    // R7 same-cycle lookup
    chk_rgb("R7", 8'd30, 24'hAABBCC);
    // R5 unused offset
    pulse_clr();
    wr(5'd8, 2'd3, 32'h12345678);
    chk_flag("R5", 1'b0);
    chk_rgb("R5", 8'd33, 24'hFF0000);
    wr(5'd4, 2'd0, 32'h66);
    chk_rgb("R5", 8'd33, 24'hFF6600);
    // R3 wrap 255 -> 0
    wr(5'd0, 2'd0, 32'd255);
    wr(5'd4, 2'd2, 32'h00010203);
    chk_rgb("R3", 8'd255, 24'h010203);
    wr(5'd4, 2'd0, 32'h09);
    chk_rgb("R3", 8'd0, 24'h090000);
    // R9 write wins over simultaneous clear
    pulse_clr();
    wr(5'd4, 2'd0, 32'h77, 1);
    chk_flag("R9", 1'b1);
    chk_rgb("R9", 8'd0, 24'h097700);
    pulse_clr();
    chk_flag("R9", 1'b0);
    // R10 reset in mid-run
    rst_ni = 0;
    @(negedge clk);
    chk_rgb("R10", 8'd0, 24'h0);
    chk_rgb("R10", 8'd30, 24'h0);
    chk_flag("R10", 1'b1);
    rst_ni = 1;
    @(negedge clk);
    wr(5'd4, 2'd0, 32'hA5);
    chk_rgb("R10", 8'd0, 24'hA50000);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule